// File: doc/BRIEF.md
# Linked-List Command Chain Walker

This block follows a chain of command packets held in main memory and hands the payload of each packet to a downstream command consumer. Each node starts with one header word. The header gives the number of payload words that follow it and the address of the next node. The walker fetches the header and streams that many payload words, one at a time. It then jumps to the linked address and repeats.

A walk ends in one of three ways. The current address carries the end marker. A repeating chain is caught by a checkpoint whose spacing doubles. In single-step mode, the walk stops after one node. While it runs, the block adds up a fixed cost per node as an estimate of bus cycles. When the walk ends it pulses `done`. With that pulse it shows the cycle estimate, the number of nodes visited, a loop flag and the address at which it stopped.

Memory is reached through a single-outstanding read request port that addresses 32-bit words. Payload leaves on a valid/ready stream.

Top module: `chain_walker`

## Requirements
- R1: A header word carries the payload word count in bits 31..24 and the next node address in bits 23..0. The walker emits exactly that many payload words, read from the word addresses directly after the header and sent in address order.
- R2: Before each header fetch the walker tests bit 23 of the current address. If it is set, the walk ends with no further memory read, so a start address with bit 23 set ends at once with zero nodes.
- R3: The memory word address is bits 20..2 of the byte address. Payload word addresses increment modulo 2^19, so a node at the top of the 2 MB space continues at word 0.
- R4: The cycle estimate starts at 0 and adds 10 for every node. It adds a further 5 plus the length for every node whose length is not zero.
- R5: Loop detection keeps a checkpoint address and a limit. The checkpoint starts as the start address and the limit starts at 32. After node index i (counting from 0), the walk stops with the loop flag set if the next address equals the checkpoint. Otherwise, when i equals the limit, the checkpoint takes the next address and the limit doubles.
- R6: With `single_step` set at start, the walk stops after one node with the loop flag clear and reports that node's next address.
- R7: Only bits 23..0 of `start_addr` are used. Bits 31..24 are ignored.
- R8: A node of length zero reads only its header and sends nothing downstream.
- R9: `done` is a one-cycle pulse at the end of each walk. With it, `done_cycles`, `done_nodes`, `done_loop` and `done_addr` (the address at which the walk stopped) are valid. `busy` is high from the cycle after `start` until `done`. While idle the block issues no read and no stream word.
- R10: A payload word offered on `out_valid` stays unchanged until `out_ready` accepts it.
- R11: Each memory read is a one-cycle `mem_req`. No new request is issued until `mem_rvalid` has returned the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (accepted when idle) |
| start_addr | input | 32 | First node byte address (bits 23..0 used) |
| single_step | input | 1 | Stop after one node |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 19 | Word address of the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Payload word valid |
| out_data | output | 32 | Payload word |
| out_ready | input | 1 | Consumer accepts the word |
| busy | output | 1 | Walk in progress |
| done | output | 1 | End-of-walk pulse |
| done_loop | output | 1 | Walk ended on loop detection |
| done_cycles | output | 32 | Cycle estimate of the walk |
| done_nodes | output | 16 | Nodes visited |
| done_addr | output | 24 | Address at which the walk stopped |

## Verification
The checks use chains of several shapes:
- A three-node chain mixing zero and non-zero lengths, which separates the per-node cost from the payload cost and shows that empty nodes stay silent.
- The same chain replayed under a pseudo-random ready pattern, which shows that back-pressure neither drops nor repeats words.
- A start address with the end bit set, and a start address with garbage in its top byte.
- A node placed at the top of memory, reached through an alias address, which exposes wrong address slicing and a missing wrap.
- A self-loop and a loop that does not include the start node. The second is caught only after the checkpoint has moved at node index 32, so it distinguishes the checkpoint schedule from a simple compare against the start address.
- Single-step mode, which must stop after one node even though a second node exists.

// File: rtl/chain_walk_pkg.sv
package chain_walk_pkg;
  localparam int LEN_W   = 8;
  localparam int LINK_W  = 24;
  localparam int END_BIT = 23;
  localparam int COST_NODE = 10;
  localparam int COST_BODY = 5;

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_HDR_REQ, S_HDR_WAIT, S_PAY_REQ,
    S_PAY_WAIT, S_PAY_SEND, S_NODE_END, S_FINISH
  } walk_state_t;

  // Cost charged for one node of the given payload length.
  function automatic logic [31:0] node_cost(input logic [LEN_W-1:0] len);
    logic [31:0] c;
    c = 32'(COST_NODE);
    if (len != '0) c = c + 32'(COST_BODY) + 32'(len);
    return c;
  endfunction

  // Word address within the wrapped memory window.
  function automatic logic [18:0] word_of(input logic [LINK_W-1:0] a);
    return a[20:2];
  endfunction
endpackage

// File: rtl/chain_cost_acc.sv
module chain_cost_acc
  import chain_walk_pkg::*;
#(
  parameter int CYC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             add,
  input  logic [LEN_W-1:0] len,
  output logic [CYC_W-1:0] total
);
  always_ff @(posedge clk) begin
    if (!rst_n)     total <= '0;
    else if (clear) total <= '0;
    else if (add)   total <= total + CYC_W'(node_cost(len));
  end

  // R4: every node charges at least the fixed per-node cost
  p_cost_grows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (add && !clear) |=> ((total - $past(total)) >= CYC_W'(COST_NODE)));
endmodule

// File: rtl/chain_loop_guard.sv
module chain_loop_guard
  import chain_walk_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int LOOP_FIRST = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic [LINK_W-1:0] init_addr,
  input  logic              advance,
  input  logic [LINK_W-1:0] next_addr,
  output logic              hit,
  output logic [CNT_W-1:0]  nodes
);
  logic [LINK_W-1:0] ckpt;
  logic [CNT_W-1:0]  limit;
  logic              at_limit;

  assign hit      = (next_addr == ckpt);
  assign at_limit = (nodes == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ckpt  <= '0;
      limit <= CNT_W'(LOOP_FIRST);
      nodes <= '0;
    end else if (init) begin
      ckpt  <= init_addr;
      limit <= CNT_W'(LOOP_FIRST);
      nodes <= '0;
    end else if (advance) begin
      nodes <= nodes + 1'b1;
      if (at_limit) begin
        ckpt <= next_addr;
        if (!limit[CNT_W-1]) limit <= limit << 1;
      end
    end
  end

  // R5: the checkpoint interval is always a power of two
  p_limit_pow2_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(limit) == 1);
endmodule

// File: rtl/chain_walker.sv
module chain_walker
  import chain_walk_pkg::*;
#(
  parameter  int CYC_W      = 32,
  parameter  int CNT_W      = 16,
  parameter  int LOOP_FIRST = 32,
  parameter  int WRAP_BITS  = 21,
  localparam int MEM_AW     = WRAP_BITS - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       start_addr,
  input  logic              single_step,
  output logic              mem_req,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              out_valid,
  output logic [31:0]       out_data,
  input  logic              out_ready,
  output logic              busy,
  output logic              done,
  output logic              done_loop,
  output logic [CYC_W-1:0]  done_cycles,
  output logic [CNT_W-1:0]  done_nodes,
  output logic [LINK_W-1:0] done_addr
);
  walk_state_t       state;
  logic [LINK_W-1:0] cur_addr, link_q;
  logic [MEM_AW-1:0] word_ptr;
  logic [LEN_W-1:0]  remain;
  logic [31:0]       data_q;
  logic              step_q, loop_q;

  // named events for the sub-blocks and assertions
  logic ev_launch, ev_hdr, ev_node_end, ev_accept, guard_hit;
  logic [LEN_W-1:0]  hdr_len;
  logic [LINK_W-1:0] hdr_link;

  assign ev_launch   = (state == S_IDLE) && start;
  assign ev_hdr      = (state == S_HDR_WAIT) && mem_rvalid;
  assign ev_node_end = (state == S_NODE_END);
  assign ev_accept   = (state == S_PAY_SEND) && out_ready;
  assign hdr_len     = mem_rdata[31:24];
  assign hdr_link    = mem_rdata[LINK_W-1:0];

  chain_cost_acc #(.CYC_W(CYC_W)) u_cost (
    .clk(clk), .rst_n(rst_n), .clear(ev_launch), .add(ev_hdr),
    .len(hdr_len), .total(done_cycles)
  );

  chain_loop_guard #(.CNT_W(CNT_W), .LOOP_FIRST(LOOP_FIRST)) u_guard (
    .clk(clk), .rst_n(rst_n), .init(ev_launch), .init_addr(start_addr[LINK_W-1:0]),
    .advance(ev_node_end), .next_addr(link_q), .hit(guard_hit), .nodes(done_nodes)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cur_addr <= '0;
      link_q   <= '0;
      word_ptr <= '0;
      remain   <= '0;
      data_q   <= '0;
      step_q   <= 1'b0;
      loop_q   <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          cur_addr <= start_addr[LINK_W-1:0];
          step_q   <= single_step;
          loop_q   <= 1'b0;
          state    <= S_CHECK;
        end
        S_CHECK:   state <= cur_addr[END_BIT] ? S_FINISH : S_HDR_REQ;
        S_HDR_REQ: state <= S_HDR_WAIT;
        S_HDR_WAIT: if (mem_rvalid) begin
          remain   <= hdr_len;
          link_q   <= hdr_link;
          word_ptr <= MEM_AW'(word_of(cur_addr)) + 1'b1;
          state    <= (hdr_len != '0) ? S_PAY_REQ : S_NODE_END;
        end
        S_PAY_REQ: state <= S_PAY_WAIT;
        S_PAY_WAIT: if (mem_rvalid) begin
          data_q <= mem_rdata;
          state  <= S_PAY_SEND;
        end
        S_PAY_SEND: if (out_ready) begin
          remain   <= remain - 1'b1;
          word_ptr <= word_ptr + 1'b1;
          state    <= (remain == LEN_W'(1)) ? S_NODE_END : S_PAY_REQ;
        end
        S_NODE_END: begin
          cur_addr <= link_q;
          if (step_q) state <= S_FINISH;
          else if (guard_hit) begin
            loop_q <= 1'b1;
            state  <= S_FINISH;
          end else state <= S_CHECK;
        end
        S_FINISH: state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  assign mem_req   = (state == S_HDR_REQ) || (state == S_PAY_REQ);
  assign mem_addr  = (state == S_HDR_REQ) ? MEM_AW'(word_of(cur_addr)) : word_ptr;
  assign out_valid = (state == S_PAY_SEND);
  assign out_data  = data_q;
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_FINISH);
  assign done_loop = loop_q;
  assign done_addr = cur_addr;

  // R10: an offered word is held while the consumer stalls
  p_hold_stream_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R11: requests are single-cycle and never back to back
  p_one_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  // R9: done is a single pulse that returns the block to idle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  // R9: an idle walker is silent on both ports
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !out_valid));
  // R2: no header is fetched from an address carrying the end marker
  p_no_fetch_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HDR_REQ) |-> !cur_addr[END_BIT]);
  // R6: a single-step walk never reports more than one node
  p_step_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && step_q) |-> (done_nodes <= CNT_W'(1) && !done_loop));
  // R8: an empty node neither reads payload nor drives the stream
  p_zero_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hdr && hdr_len == '0) |=> (!mem_req && !out_valid));
  // R7: the launch address is the start input with its top byte removed
  p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_launch |=> (cur_addr == LINK_W'($past(start_addr) & 32'h00FF_FFFF)));
endmodule

// File: tb/tb_chain_walker.sv
`timescale 1ns/1ps
module tb_chain_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic        single_step = 1'b0;
  logic        mem_req, mem_rvalid;
  logic [18:0] mem_addr;
  logic [31:0] mem_rdata;
  logic        out_valid, out_ready;
  logic [31:0] out_data;
  logic        busy, done, done_loop;
  logic [31:0] done_cycles;
  logic [15:0] done_nodes;
  logic [23:0] done_addr;

  always #2.5 clk = ~clk;

  chain_walker dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .single_step(single_step), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready), .busy(busy), .done(done),
    .done_loop(done_loop), .done_cycles(done_cycles), .done_nodes(done_nodes),
    .done_addr(done_addr)
  );

  // memory model: 4096-word window indexed by word address bits 11..0, latency 2
  logic [31:0] mem [4096];
  logic        req_d1 = 1'b0, pending = 1'b0;
  logic [18:0] addr_d1 = '0;
  logic        rv_q = 1'b0;
  logic [31:0] rd_q = '0;
  int          nreq = 0, proto_err = 0;
  logic [18:0] req_log [64];
  always @(posedge clk) begin
    req_d1  <= mem_req;
    addr_d1 <= mem_addr;
    rv_q    <= req_d1;
    rd_q    <= mem[addr_d1[11:0]];
    if (mem_req) begin
      if (pending) proto_err <= proto_err + 1;
      req_log[nreq[5:0]] <= mem_addr;
      nreq <= nreq + 1;
    end
    if (mem_req) pending <= 1'b1;
    else if (rv_q) pending <= 1'b0;
  end
  assign mem_rvalid = rv_q;
  assign mem_rdata  = rd_q;

  // consumer with optional pseudo-random back-pressure
  logic [7:0] lf = 8'hA5;
  logic       rdy_mode = 1'b0;
  always @(posedge clk) lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
  assign out_ready = rdy_mode ? lf[0] : 1'b1;

  logic [31:0] cap [256];
  int          ncap = 0;
  always @(posedge clk) if (out_valid && out_ready) begin
    cap[ncap[7:0]] <= out_data;
    ncap <= ncap + 1;
  end

  int n_checks = 0, n_fail = 0;
  logic [31:0] exp_w [256];
  int          nexp;
  int          cap_base, req_base;
  logic [31:0] r_cyc;
  logic [15:0] r_nodes;
  logic        r_loop;
  logic [23:0] r_addr;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  function automatic logic [11:0] idx(input logic [23:0] a);
    return a[13:2];
  endfunction

  function automatic logic [31:0] pay(input logic [23:0] a, input int j);
    return 32'hA000_0000 | ({8'h0, a} << 4) | 32'(j);
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    nexp = 0;
  endtask

  task automatic put_node(input logic [23:0] a, input int len, input logic [23:0] nxt);
    mem[idx(a)] = {8'(len), nxt};
    for (int j = 0; j < len; j++) mem[12'(idx(a) + 12'(j + 1))] = pay(a, j);
  endtask

  task automatic push_exp(input logic [23:0] a, input int len);
    for (int j = 0; j < len; j++) begin
      exp_w[nexp[7:0]] = pay(a, j);
      nexp++;
    end
  endtask

  function automatic logic [31:0] cost_of(input int len);
    return (len == 0) ? 32'd10 : 32'(15 + len);
  endfunction

  task automatic run_walk(input logic [31:0] sa, input bit step, input string tag);
    int t;
    cap_base = ncap;
    req_base = nreq;
    @(negedge clk);
    start = 1'b1; start_addr = sa; single_step = step;
    @(negedge clk);
    start = 1'b0; single_step = 1'b0;
    chk(busy == 1'b1, {tag, " R9 busy"}, busy, 1);
    t = 0;
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(done == 1'b1, {tag, " R9 done timeout"}, done, 1);
    r_cyc = done_cycles; r_nodes = done_nodes; r_loop = done_loop; r_addr = done_addr;
    @(negedge clk);
    chk(!done && !busy, {tag, " R9 pulse"}, {done, busy}, 0);
  endtask

  task automatic chk_words(input string tag);
    chk(ncap - cap_base == nexp, {tag, " R1 word count"}, ncap - cap_base, nexp);
    for (int k = 0; k < nexp; k++)
      chk(cap[8'(cap_base + k)] == exp_w[k[7:0]], {tag, " R1 word"}, cap[8'(cap_base + k)], exp_w[k[7:0]]);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !mem_req && !out_valid, "reset R9 quiet",
        {busy, done, mem_req, out_valid}, 0);
  endtask

  task automatic t_basic(input bit stall, input string tag);
    clear_mem();
    put_node(24'h000100, 2, 24'h000200);
    put_node(24'h000200, 0, 24'h000300);
    put_node(24'h000300, 3, 24'hFFFFFF);
    push_exp(24'h000100, 2); push_exp(24'h000300, 3);
    rdy_mode = stall;
    run_walk(32'h0000_0100, 1'b0, tag);
    rdy_mode = 1'b0;
    chk(r_cyc == cost_of(2) + cost_of(0) + cost_of(3), {tag, " R4 cycles"}, r_cyc, 45);
    chk(r_nodes == 16'd3 && !r_loop, {tag, " R9 nodes"}, r_nodes, 3);
    chk(r_addr == 24'hFFFFFF, {tag, " R2 stop addr"}, r_addr, 24'hFFFFFF);
    // R8: 3 headers plus 5 payload reads; the empty node adds only its header
    chk(nreq - req_base == 8, {tag, " R8 reads"}, nreq - req_base, 8);
    chk_words({tag, stall ? " R10" : ""});
  endtask

  task automatic t_end_now();
    clear_mem();
    run_walk(32'h0080_0000, 1'b0, "endnow");
    chk(r_nodes == 0 && r_cyc == 0, "endnow R2 zero", {r_nodes, r_cyc}, 0);
    chk(nreq - req_base == 0, "endnow R2 no read", nreq - req_base, 0);
  endtask

  task automatic t_mask();
    clear_mem();
    put_node(24'h000100, 1, 24'h800000);
    push_exp(24'h000100, 1);
    run_walk(32'hAB00_0100, 1'b0, "mask");
    chk(r_nodes == 1 && r_cyc == cost_of(1), "mask R7 walk", r_cyc, 16);
    chk(req_log[req_base[5:0]] == 19'h00040, "mask R7 hdr addr", req_log[req_base[5:0]], 19'h40);
    chk_words("mask R7");
  endtask

  task automatic t_wrap();
    clear_mem();
    mem[12'hFFF] = {8'd2, 24'h800010};
    mem[12'h000] = 32'h1111_0000;
    mem[12'h001] = 32'h1111_0001;
    exp_w[0] = 32'h1111_0000; exp_w[1] = 32'h1111_0001; nexp = 2;
    run_walk(32'h003F_FFFC, 1'b0, "wrap");
    chk(req_log[6'(req_base)] == 19'h7FFFF, "wrap R3 hdr", req_log[6'(req_base)], 19'h7FFFF);
    chk(req_log[6'(req_base + 1)] == 19'h00000, "wrap R3 pay0", req_log[6'(req_base + 1)], 0);
    chk(req_log[6'(req_base + 2)] == 19'h00001, "wrap R3 pay1", req_log[6'(req_base + 2)], 1);
    chk(r_addr == 24'h800010 && r_cyc == cost_of(2), "wrap R2 end", r_addr, 24'h800010);
    chk_words("wrap R3");
  endtask

  task automatic t_step();
    clear_mem();
    put_node(24'h000100, 2, 24'h000200);
    put_node(24'h000200, 1, 24'h800000);
    push_exp(24'h000100, 2);
    run_walk(32'h0000_0100, 1'b1, "step");
    chk(r_nodes == 1 && !r_loop, "step R6 one node", r_nodes, 1);
    chk(r_addr == 24'h000200, "step R6 next addr", r_addr, 24'h200);
    chk(r_cyc == cost_of(2), "step R4 cycles", r_cyc, 17);
    chk_words("step R6");
  endtask

  task automatic t_self_loop();
    clear_mem();
    put_node(24'h000040, 1, 24'h000040);
    push_exp(24'h000040, 1);
    run_walk(32'h0000_0040, 1'b0, "self");
    chk(r_loop && r_nodes == 1, "self R5 loop", {r_loop, r_nodes}, 17'h10001);
    chk(r_cyc == cost_of(1), "self R4 cycles", r_cyc, 16);
    chk_words("self R5");
  endtask

  task automatic t_late_loop();
    // start node is outside the cycle; caught after the checkpoint moves at index 32
    clear_mem();
    put_node(24'h000100, 0, 24'h000200);
    put_node(24'h000200, 0, 24'h000300);
    put_node(24'h000300, 0, 24'h000200);
    run_walk(32'h0000_0100, 1'b0, "late");
    chk(r_loop == 1'b1, "late R5 flag", r_loop, 1);
    chk(r_nodes == 16'd35, "late R5 nodes", r_nodes, 35);
    chk(r_cyc == 32'd350, "late R4 cycles", r_cyc, 350);
    chk(r_addr == 24'h000200, "late R5 addr", r_addr, 24'h200);
    chk(ncap == cap_base, "late R8 silent", ncap - cap_base, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic(1'b0, "basic");
    t_basic(1'b1, "stall");
    t_end_now();
    t_mask();
    t_wrap();
    t_step();
    t_self_loop();
    t_late_loop();
    chk(proto_err == 0, "R11 overlapping request", proto_err, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule